// File: doc/BRIEF.md
# Two-Slot Transmit Ping-Pong Queue

This block sits between a host register port and a frame-sending engine. Software stages a frame by writing the buffer start address into one register. It then writes the byte length into another register, and that length write hands the pair to the queue. The queue holds at most two frames: one that the engine is sending and one waiting behind it. When the engine signals that a frame has finished, the waiting frame moves up. The engine then receives a start pulse carrying the promoted frame's address and length.

Software watches two status bits. The ready bit says a new frame may be staged. The idle bit says nothing is held at all. A sticky completion flag and a sticky overflow flag are cleared by writing ones to them. The interrupt line is the completion flag gated by a mask. One register sets the mask and a separate register clears it. A global enable bit gates all of this. Clearing it empties both slots at once.

The control core is a four-state machine:
- **ST_IDLE**: no frame held.
- **ST_SEND**: one frame active.
- **ST_SEND_Q**: one frame active and one queued.
- **ST_HANDOFF**: the active frame has finished and the queued frame is being promoted.

The transitions are:
- *launch*: ST_IDLE to ST_SEND on a commit.
- *enqueue*: ST_SEND to ST_SEND_Q on a commit.
- *drain*: ST_SEND to ST_IDLE on done.
- *swap*: ST_SEND to ST_HANDOFF on a commit and done in the same cycle.
- *retire*: ST_SEND_Q to ST_HANDOFF on done.
- *promote*: ST_HANDOFF to ST_SEND.
- *flush*: any state to ST_IDLE when the enable bit is cleared.

Top module: `txpp_top`

## Requirements
- R1: The register map uses word addresses. Word 1 stages the buffer address and word 2 takes the length in its low LEN_W bits. A length write commits the entry. From ST_IDLE, tx_start_o is high for exactly one cycle after the write edge, with tx_addr_o and tx_len_o equal to the committed pair.
- R2: At most two frames are held. A length write while two are held is ignored and sets the sticky overflow flag in status bit 3.
- R3: Status (word 3) bit 0, ready, reads 1 only when the enable bit is set and fewer than two frames are held.
- R4: Status bit 1, idle, reads 1 only when no frame is active and none is queued.
- R5: Status bit 2 is set by each frame_done_i pulse that arrives while a frame is active. Writing ones to status bits 2 or 3 clears them, and a new set event in the same cycle wins over the clear.
- R6: Control word 0 bit 0 is the transmit enable. Length writes while it is clear are dropped. Writing it clear empties both slots and returns the queue to idle.
- R7: A done pulse with a frame queued gives one handoff cycle with ready low. The next cycle then pulses tx_start_o with the queued frame, and ready reads 1 again.
- R8: A done pulse and a commit in the same cycle, with one frame held, queue the new frame. After the handoff cycle the new frame is launched.
- R9: irq_o is the completion flag ANDed with a mask. Writing bit 0 to word 4 sets the mask and writing bit 0 to word 5 clears it. The mask reads back at word 6 bit 0.
- R10: After reset, status reads 0b0010, and irq_o, tx_start_o and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address (write and read) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on reg_addr_i |
| frame_done_i | input | 1 | Engine pulse: active frame finished |
| tx_start_o | output | 1 | One-cycle launch pulse to the engine |
| tx_addr_o | output | DATA_W | Buffer address of the active frame |
| tx_len_o | output | LEN_W | Byte length of the active frame |
| irq_o | output | 1 | Transmit-complete interrupt |

## Verification
The bench builds the block with DATA_W = 32 and LEN_W = 11. This is enough to tell buffer addresses and lengths apart in every launched frame, and to check the exact bits returned by the length field. The queue depth is fixed at two, so every state and every transition of the four-state machine can be reached within a short sweep. The sweep runs bursts of one and two frames with computed addresses and lengths. It also visits the overflow, swap, flush and disabled-write corners.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_SEND_Q  = 2'd2,
        ST_HANDOFF = 2'd3
    } txpp_state_e;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CTRL     = 3'd0;
    localparam logic [REG_AW-1:0] RA_BUFADDR  = 3'd1;
    localparam logic [REG_AW-1:0] RA_BUFLEN   = 3'd2;
    localparam logic [REG_AW-1:0] RA_STAT     = 3'd3;
    localparam logic [REG_AW-1:0] RA_IRQ_SET  = 3'd4;
    localparam logic [REG_AW-1:0] RA_IRQ_CLR  = 3'd5;
    localparam logic [REG_AW-1:0] RA_IRQ_MASK = 3'd6;

    localparam int SB_READY = 0;
    localparam int SB_IDLE  = 1;
    localparam int SB_DONE  = 2;
    localparam int SB_OVF   = 3;
endpackage

// File: rtl/txpp_slot_fsm.sv
module txpp_slot_fsm
    import txpp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] commit_addr_i,
    input  logic [LEN_W-1:0]  commit_len_i,
    input  logic              frame_done_i,
    input  logic              flush_i,
    output logic              slot_free_o,
    output logic              empty_o,
    output logic              reject_o,
    output logic              done_evt_o,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_addr_o,
    output logic [LEN_W-1:0]  tx_len_o
);
    txpp_state_e st_q, st_d;
    logic              launch_new, store_pend, promote;
    logic [DATA_W-1:0] act_addr_q, pend_addr_q;
    logic [LEN_W-1:0]  act_len_q, pend_len_q;
    logic              start_q;

    // next-state and control decode
    always_comb begin
        st_d       = st_q;
        launch_new = 1'b0;
        store_pend = 1'b0;
        promote    = 1'b0;
        reject_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (commit_i) begin
                    st_d       = ST_SEND;
                    launch_new = 1'b1;
                end
            end
            ST_SEND: begin
                if (commit_i && frame_done_i) begin
                    st_d       = ST_HANDOFF;
                    store_pend = 1'b1;
                end else if (commit_i) begin
                    st_d       = ST_SEND_Q;
                    store_pend = 1'b1;
                end else if (frame_done_i) begin
                    st_d = ST_IDLE;
                end
            end
            ST_SEND_Q: begin
                reject_o = commit_i;
                if (frame_done_i) st_d = ST_HANDOFF;
            end
            ST_HANDOFF: begin
                reject_o = commit_i;
                st_d     = ST_SEND;
                promote  = 1'b1;
            end
        endcase
        if (flush_i) begin
            st_d       = ST_IDLE;
            launch_new = 1'b0;
            store_pend = 1'b0;
            promote    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // slot datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_addr_q  <= '0;
            act_len_q   <= '0;
            pend_addr_q <= '0;
            pend_len_q  <= '0;
            start_q     <= 1'b0;
        end else begin
            start_q <= launch_new | promote;
            if (launch_new) begin
                act_addr_q <= commit_addr_i;
                act_len_q  <= commit_len_i;
            end else if (promote) begin
                act_addr_q <= pend_addr_q;
                act_len_q  <= pend_len_q;
            end
            if (store_pend) begin
                pend_addr_q <= commit_addr_i;
                pend_len_q  <= commit_len_i;
            end
        end
    end

    // outputs
    always_comb begin
        slot_free_o = (st_q == ST_IDLE) || (st_q == ST_SEND);
        empty_o     = (st_q == ST_IDLE);
        done_evt_o  = frame_done_i && ((st_q == ST_SEND) || (st_q == ST_SEND_Q));
        tx_start_o  = start_q;
        tx_addr_o   = act_addr_q;
        tx_len_o    = act_len_q;
    end

    assert_launch_in_send_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_start_o |-> (st_q == ST_SEND));
    assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_SEND_Q && !frame_done_i && !flush_i) |=> (st_q == ST_SEND_Q));
    assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (st_q == ST_IDLE));
    assert_handoff_promotes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_HANDOFF && !flush_i) |=> (st_q == ST_SEND && tx_start_o));
endmodule

// File: rtl/txpp_irq.sv
module txpp_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mask_set_i,
    input  logic mask_clr_i,
    input  logic done_flag_i,
    output logic mask_o,
    output logic irq_o
);
    logic mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         mask_q <= 1'b0;
        else if (mask_set_i) mask_q <= 1'b1;
        else if (mask_clr_i) mask_q <= 1'b0;
    end

    always_comb begin
        mask_o = mask_q;
        irq_o  = done_flag_i & mask_q;
    end

    assert_mask_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_set_i |=> mask_o);
    assert_mask_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_clr_i && !mask_set_i) |=> !irq_o);
endmodule

// File: rtl/txpp_regs.sv
module txpp_regs
    import txpp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              slot_free_i,
    input  logic              empty_i,
    input  logic              reject_i,
    input  logic              done_evt_i,
    input  logic              mask_i,
    output logic              commit_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] staged_addr_o,
    output logic              mask_set_o,
    output logic              mask_clr_o,
    output logic              done_flag_o
);
    logic              en_q, done_q, ovf_q;
    logic [DATA_W-1:0] stage_q;
    logic              wr_ctrl, wr_stat, clr_done, clr_ovf;

    always_comb begin
        wr_ctrl       = we_i && (addr_i == RA_CTRL);
        wr_stat       = we_i && (addr_i == RA_STAT);
        clr_done      = wr_stat && wdata_i[SB_DONE];
        clr_ovf       = wr_stat && wdata_i[SB_OVF];
        commit_o      = we_i && (addr_i == RA_BUFLEN) && en_q;
        flush_o       = wr_ctrl && !wdata_i[0];
        mask_set_o    = we_i && (addr_i == RA_IRQ_SET) && wdata_i[0];
        mask_clr_o    = we_i && (addr_i == RA_IRQ_CLR) && wdata_i[0];
        staged_addr_o = stage_q;
        done_flag_o   = done_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q    <= 1'b0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
            stage_q <= '0;
        end else begin
            if (wr_ctrl) en_q <= wdata_i[0];
            if (we_i && addr_i == RA_BUFADDR) stage_q <= wdata_i;
            done_q <= done_evt_i | (done_q & ~clr_done);
            ovf_q  <= reject_i   | (ovf_q  & ~clr_ovf);
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_CTRL:     rdata_o[0] = en_q;
            RA_BUFADDR:  rdata_o = stage_q;
            RA_STAT: begin
                rdata_o[SB_READY] = en_q & slot_free_i;
                rdata_o[SB_IDLE]  = empty_i;
                rdata_o[SB_DONE]  = done_q;
                rdata_o[SB_OVF]   = ovf_q;
            end
            RA_IRQ_MASK: rdata_o[0] = mask_i;
            default:     rdata_o = '0;
        endcase
    end

    assert_done_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_evt_i |=> done_flag_o);
    assert_no_overflow_loss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_q && !clr_ovf) |=> ovf_q);
    assert_disabled_no_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |-> !commit_o);
endmodule

// File: rtl/txpp_top.sv
module txpp_top
    import txpp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              frame_done_i,
    output logic              tx_start_o,
    output logic [DATA_W-1:0] tx_addr_o,
    output logic [LEN_W-1:0]  tx_len_o,
    output logic              irq_o
);
    logic              commit, flush, slot_free, empty, reject, done_evt;
    logic              mask_set, mask_clr, mask, done_flag;
    logic [DATA_W-1:0] staged_addr;

    txpp_regs #(.DATA_W(DATA_W)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o),
        .slot_free_i(slot_free), .empty_i(empty), .reject_i(reject),
        .done_evt_i(done_evt), .mask_i(mask),
        .commit_o(commit), .flush_o(flush), .staged_addr_o(staged_addr),
        .mask_set_o(mask_set), .mask_clr_o(mask_clr), .done_flag_o(done_flag)
    );

    txpp_slot_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) fsm_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .commit_i(commit), .commit_addr_i(staged_addr),
        .commit_len_i(reg_wdata_i[LEN_W-1:0]),
        .frame_done_i(frame_done_i), .flush_i(flush),
        .slot_free_o(slot_free), .empty_o(empty), .reject_o(reject),
        .done_evt_o(done_evt),
        .tx_start_o(tx_start_o), .tx_addr_o(tx_addr_o), .tx_len_o(tx_len_o)
    );

    txpp_irq irq_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .mask_set_i(mask_set), .mask_clr_i(mask_clr),
        .done_flag_i(done_flag), .mask_o(mask), .irq_o(irq_o)
    );

    assert_idle_not_ready_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty |-> slot_free);
endmodule

// File: tb/txpp_top_tb_top.sv
module txpp_top_tb_top;
    localparam int DW = 32;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          done = 1'b0;
    logic          tx_start;
    logic [DW-1:0] tx_addr;
    logic [LW-1:0] tx_len;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txpp_top #(.DATA_W(DW), .LEN_W(LW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .frame_done_i(done),
        .tx_start_o(tx_start), .tx_addr_o(tx_addr), .tx_len_o(tx_len), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic chk_stat(input string req, input logic [3:0] exp);
        logic [DW-1:0] v;
        rd(3'd3, v);
        chk(req, {60'd0, v[3:0]}, {60'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] a0, a1;
        logic [LW-1:0] l0, l1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk_stat("R10 status", 4'b0010);
        chk("R10 irq", {63'd0, irq}, 64'd0);
        chk("R10 tx_start", {63'd0, tx_start}, 64'd0);
        rd(3'd6, v);
        chk("R10 mask", {63'd0, v[0]}, 64'd0);

        // R6 length write while disabled is dropped
        wr(3'd1, 32'hDEAD_0000);
        wr(3'd2, 32'd99);
        chk("R6 no launch while disabled", {63'd0, tx_start}, 64'd0);
        chk_stat("R6 still idle", 4'b0010);

        wr(3'd0, 32'd1);
        chk_stat("R3 ready when enabled and empty", 4'b0011);

        // Sweep: bursts of one and two frames, R1 R3 R4 R7
        for (int burst = 1; burst <= 2; burst++) begin
            for (int rep = 0; rep < 8; rep++) begin
                a0 = 32'h1000_0000 + burst * 256 + rep * 16;
                a1 = a0 + 32'h0000_8000;
                l0 = LW'(60 + rep * 7 + burst);
                l1 = LW'(1500 - rep * 11);
                wr(3'd1, a0);
                wr(3'd2, {{(DW-LW){1'b0}}, l0});
                chk("R1 launch pulse", {63'd0, tx_start}, 64'd1);
                chk("R1 launch addr", {32'd0, tx_addr}, {32'd0, a0});
                chk("R1 launch len", {53'd0, tx_len}, {53'd0, l0});
                chk_stat("R3 one held ready", 4'b0001);
                if (burst == 2) begin
                    wr(3'd1, a1);
                    wr(3'd2, {{(DW-LW){1'b0}}, l1});
                    chk("R1 no launch when queued", {63'd0, tx_start}, 64'd0);
                    chk_stat("R3 two held not ready", 4'b0000);
                    pulse_done();
                    chk_stat("R7 handoff not ready", 4'b0100);
                    chk("R7 handoff no pulse", {63'd0, tx_start}, 64'd0);
                    @(negedge clk);
                    chk("R7 promote pulse", {63'd0, tx_start}, 64'd1);
                    chk("R7 promote addr", {32'd0, tx_addr}, {32'd0, a1});
                    chk("R7 promote len", {53'd0, tx_len}, {53'd0, l1});
                    chk_stat("R7 ready again", 4'b0101);
                end
                pulse_done();
                chk_stat("R4 idle after last done", 4'b0111);
                wr(3'd3, 32'h4);
                chk_stat("R5 done cleared by write one", 4'b0011);
            end
        end

        // R2 overflow
        wr(3'd1, 32'hA000_0000); wr(3'd2, 32'd64);
        wr(3'd1, 32'hB000_0000); wr(3'd2, 32'd65);
        wr(3'd1, 32'hC000_0000); wr(3'd2, 32'd66);
        chk_stat("R2 overflow flag", 4'b1000);
        pulse_done();
        @(negedge clk);
        chk("R2 second frame kept", {32'd0, tx_addr}, 64'hB000_0000);
        pulse_done();
        chk_stat("R2 third frame dropped", 4'b1111);
        chk("R2 no extra launch", {63'd0, tx_start}, 64'd0);

        // R5 W1C of overflow only
        wr(3'd3, 32'h8);
        chk_stat("R5 ovf cleared done kept", 4'b0111);

        // R9 mask
        chk("R9 irq masked", {63'd0, irq}, 64'd0);
        wr(3'd4, 32'd1);
        chk("R9 irq on", {63'd0, irq}, 64'd1);
        rd(3'd6, v);
        chk("R9 mask readback", {63'd0, v[0]}, 64'd1);
        wr(3'd5, 32'd1);
        chk("R9 irq off", {63'd0, irq}, 64'd0);
        wr(3'd4, 32'd1);
        wr(3'd3, 32'h4);
        chk("R9 irq drops with flag", {63'd0, irq}, 64'd0);

        // R5 set wins over clear
        wr(3'd1, 32'h2000_0000); wr(3'd2, 32'd80);
        @(negedge clk);
        we = 1'b1; addr = 3'd3; wdata = 32'h4; done = 1'b1;
        @(negedge clk);
        we = 1'b0; done = 1'b0;
        chk_stat("R5 set wins over clear", 4'b0111);
        chk("R9 irq after set", {63'd0, irq}, 64'd1);
        wr(3'd3, 32'hC);

        // R8 done and commit in same cycle
        wr(3'd1, 32'h3000_0000); wr(3'd2, 32'd90);
        wr(3'd1, 32'h3100_0000);
        @(negedge clk);
        we = 1'b1; addr = 3'd2; wdata = 32'd91; done = 1'b1;
        @(negedge clk);
        we = 1'b0; done = 1'b0;
        chk_stat("R8 swap handoff", 4'b0100);
        @(negedge clk);
        chk("R8 swap launch", {63'd0, tx_start}, 64'd1);
        chk("R8 swap addr", {32'd0, tx_addr}, 64'h3100_0000);
        chk("R8 swap len", {53'd0, tx_len}, 64'd91);
        pulse_done();
        wr(3'd3, 32'hC);

        // R6 flush empties queue
        wr(3'd1, 32'h4000_0000); wr(3'd2, 32'd70);
        wr(3'd1, 32'h4100_0000); wr(3'd2, 32'd71);
        wr(3'd0, 32'd0);
        chk_stat("R6 flushed idle", 4'b0010);
        wr(3'd0, 32'd1);
        pulse_done();
        chk_stat("R6 stray done ignored", 4'b0011);
        wr(3'd1, 32'h5000_0000); wr(3'd2, 32'd72);
        chk("R6 fresh launch addr", {32'd0, tx_addr}, 64'h5000_0000);
        pulse_done();
        @(negedge clk);
        chk("R6 old queued not launched", {63'd0, tx_start}, 64'd0);
        chk_stat("R6 idle after fresh", 4'b0111);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule